// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs the pin-level timing of a processor bus whose address and data share one set of pins. A requester hands it a read or write with a 20-bit byte address and, for writes, 16 bits of data. The sequencer then plays out one bus cycle. The first state drives the address and pulses an address latch strobe so that external latches can hold it. The second state turns the shared pins around. The data moves in the third and fourth states. Wait states are added after the third state for as long as the addressed target holds its ready line low.

Two outputs steer an external data transceiver: an enable and a direction bit. Between cycles the bus rests in idle states with every pin released. A new request can be taken in the last state of a running cycle, so back-to-back transfers run with no idle gap. Read data is captured from the pins at the end of the last state and presented to the requester with a one-clock valid pulse.

Top module: `mux_bus_seq`

## Requirements
- R1: While rst_ni is low and on the first edge after release, phase_o is 0 (idle), ale_o, ad_oe_o, den_o, dtr_o and rdata_valid_o are 0, and req_ready_o is 1.
- R2: A request is accepted on a rising edge where req_valid_i and req_ready_o are both 1. In the next clock, which is state T1, ale_o is 1, ad_oe_o is 1, ad_o equals the request address, dtr_o equals req_write_i (1 = transmit/write) and den_o is 0.
- R3: In T2 of a read, ad_oe_o and den_o are 0. In T2 of a write, ad_oe_o and den_o are 1 and ad_o carries the write data zero-extended in its low 16 bits. In T3, wait states and T4, den_o is 1, and ad_oe_o is 1 only for writes.
- R4: bus_rdy_i is sampled on the rising edge that ends T3 and on the edge that ends each wait state. Each low sample adds one wait state.
- R5: T4 follows the first high sample of bus_rdy_i, so a cycle with n low samples lasts 4+n clocks.
- R6: For a read, ad_i is captured on the edge that ends T4. In the next clock rdata_o holds that value and rdata_valid_o is 1 for exactly that clock. rdata_o changes only when rdata_valid_o is 1, and writes never raise rdata_valid_o.
- R7: req_ready_o is 1 only in idle and in T4. A request accepted in T4 starts its T1 on the very next clock, with the new address on ad_o.
- R8: With no request pending after T4, the sequencer returns to idle with ale_o, ad_oe_o, den_o and dtr_o all 0.
- R9: phase_o reports the current state as 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4.
- R10: A request raised and dropped while req_ready_o is 0 (T1 to T3 or a wait state) is not accepted: after the running T4 the bus goes to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 20 | Byte address |
| req_wdata_i | input | 16 | Write data |
| req_ready_o | output | 1 | Request can be accepted this clock |
| rdata_o | output | 16 | Last captured read data |
| rdata_valid_o | output | 1 | One-clock pulse when rdata_o is new |
| ad_o | output | 20 | Shared address/data pins, outgoing value |
| ad_oe_o | output | 1 | Drive enable for the shared pins |
| ad_i | input | 16 | Shared pins, incoming data |
| ale_o | output | 1 | Address latch strobe |
| bus_rdy_i | input | 1 | Target ready |
| den_o | output | 1 | Transceiver enable |
| dtr_o | output | 1 | Transceiver direction, 1 = transmit |
| phase_o | output | 3 | Current bus state code |

## Verification
The assertions watch the state order on every clock. T1 must be followed by T2 and T2 by T3. A low ready sample must lead to a wait state and a high one to T4, and a request taken in T4 must lead straight to T1. The assertions also check that the address strobe only appears while the address is driven, that the pins are never driven while the transceiver is enabled for receive, and that read data changes only with its valid pulse. The exact values on the pins in each state, the number of wait states for a given ready pattern, the captured read data, back-to-back chaining and the refusal of a request raised mid-cycle can only be seen through the bench's scenarios.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;
endpackage

// File: rtl/mbs_fsm.sv
module mbs_fsm
  import mbs_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   bus_rdy_i,
  output phase_e phase_o,
  output logic   accept_ready_o
);
  phase_e phase_q, phase_d;

  assign accept_ready_o = (phase_q == PH_IDLE) || (phase_q == PH_T4);
  assign phase_o = phase_q;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: phase_d = start_i ? PH_T1 : PH_IDLE;
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = PH_T3;
      PH_T3,
      PH_TW:   phase_d = bus_rdy_i ? PH_T4 : PH_TW;
      PH_T4:   phase_d = start_i ? PH_T1 : PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  // R5: minimum cycle of four states
  a_r5_t1_then_t2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_T1 |=> phase_q == PH_T2);
  a_r5_t2_then_t3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_T2 |=> phase_q == PH_T3);
  a_r4_wait_on_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_T3 || phase_q == PH_TW) && !bus_rdy_i |=> phase_q == PH_TW);
  a_r5_t4_on_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_T3 || phase_q == PH_TW) && bus_rdy_i |=> phase_q == PH_T4);
  a_r7_chain_from_t4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_T4 && start_i |=> phase_q == PH_T1);
  a_r10_no_start_midcycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_ready_o |=> phase_q != PH_T1);
endmodule

// File: rtl/mbs_datapath.sv
module mbs_datapath
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  phase_e            phase_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o
);
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              data_phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start_i) begin
      wr_q    <= req_write_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  assign data_phase = (phase_i == PH_T2) || (phase_i == PH_T3) ||
                      (phase_i == PH_TW) || (phase_i == PH_T4);

  always_comb begin
    ad_o    = '0;
    ad_oe_o = 1'b0;
    if (phase_i == PH_T1) begin
      ad_o    = addr_q;
      ad_oe_o = 1'b1;
    end else if (data_phase && wr_q) begin
      ad_o    = ADDR_W'(wdata_q);
      ad_oe_o = 1'b1;
    end
  end

  // read capture at the edge closing T4
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o       <= '0;
      rdata_valid_o <= 1'b0;
    end else begin
      rdata_valid_o <= (phase_i == PH_T4) && !wr_q;
      if ((phase_i == PH_T4) && !wr_q) rdata_o <= ad_i;
    end
  end

  assign wr_o = wr_q;

  a_r6_rdata_only_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> rdata_valid_o);
  a_r6_valid_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |=> !rdata_valid_o || $past(phase_i) == PH_T4);
endmodule

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
(
  input  phase_e phase_i,
  input  logic   wr_i,
  output logic   ale_o,
  output logic   den_o,
  output logic   dtr_o
);
  logic active;
  logic xfer_rd;
  logic xfer_wr;

  assign active  = phase_i != PH_IDLE;
  assign xfer_rd = (phase_i == PH_T3) || (phase_i == PH_TW) || (phase_i == PH_T4);
  assign xfer_wr = xfer_rd || (phase_i == PH_T2);

  assign ale_o = phase_i == PH_T1;
  assign dtr_o = active && wr_i;
  // reads keep the transceiver off through the T2 turnaround
  assign den_o = wr_i ? xfer_wr : xfer_rd;
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o,
  output logic [ADDR_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic              ale_o,
  input  logic              bus_rdy_i,
  output logic              den_o,
  output logic              dtr_o,
  output logic [2:0]        phase_o
);
  phase_e phase;
  logic   start;
  logic   wr;

  assign start   = req_valid_i && req_ready_o;
  assign phase_o = phase;

  mbs_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start),
    .bus_rdy_i      (bus_rdy_i),
    .phase_o        (phase),
    .accept_ready_o (req_ready_o)
  );

  mbs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start),
    .req_write_i   (req_write_i),
    .req_addr_i    (req_addr_i),
    .req_wdata_i   (req_wdata_i),
    .phase_i       (phase),
    .ad_i          (ad_i),
    .wr_o          (wr),
    .ad_o          (ad_o),
    .ad_oe_o       (ad_oe_o),
    .rdata_o       (rdata_o),
    .rdata_valid_o (rdata_valid_o)
  );

  mbs_ctrl u_ctrl (
    .phase_i (phase),
    .wr_i    (wr),
    .ale_o   (ale_o),
    .den_o   (den_o),
    .dtr_o   (dtr_o)
  );

  a_r2_strobe_with_address: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> ad_oe_o && !den_o);
  a_r3_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    den_o && !dtr_o |-> !ad_oe_o);
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase == PH_IDLE |-> !ale_o && !ad_oe_o && !den_o && !dtr_o);
endmodule

// File: tb/sim_mux_bus_seq.sv
`timescale 1ns/1ps
module sim_mux_bus_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready;
  logic [15:0] rdata;
  logic        rdata_valid;
  logic [19:0] ad_out;
  logic        ad_oe;
  logic [15:0] ad_in = '0;
  logic        ale, bus_rdy = 1'b1, den, dtr;
  logic [2:0]  phase;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mux_bus_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ready_o(req_ready),
    .rdata_o(rdata), .rdata_valid_o(rdata_valid), .ad_o(ad_out), .ad_oe_o(ad_oe),
    .ad_i(ad_in), .ale_o(ale), .bus_rdy_i(bus_rdy), .den_o(den), .dtr_o(dtr),
    .phase_o(phase)
  );

  // {write, addr[19:0], data[15:0], waits[3:0]}
  localparam int NV = 6;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 20'hFFFF0, 16'h1234, 4'd0},
    {1'b1, 20'h00003, 16'hBEEF, 4'd0},
    {1'b0, 20'h3A5C1, 16'h8001, 4'd1},
    {1'b1, 20'h80000, 16'hFFFF, 4'd3},
    {1'b0, 20'h003FF, 16'h0000, 4'd5},
    {1'b1, 20'h7FFFF, 16'h5A5A, 4'd2}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Starts at a negedge; if pre_started the bus is already in T1.
  task automatic run_txn(input bit wr, input logic [19:0] a, input logic [15:0] d,
                         input int waits, input bit pre_started, input bit poke,
                         input bit chain, input bit c_wr, input logic [19:0] c_a,
                         input logic [15:0] c_d);
    if (!pre_started) begin
      chk(req_ready == 1'b1, "R7 ready when idle", req_ready, 1);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
    end
    // T1
    chk(phase == 3'd1, "R9 phase T1", phase, 1);
    chk(ale && ad_oe && !den, "R2 strobe/drive in T1", {ale, ad_oe, den}, 3'b110);
    chk(ad_out == a, "R2 address on pins", ad_out, a);
    chk(dtr == wr, "R2 direction", dtr, wr);
    chk(req_ready == 1'b0, "R7 not ready in T1", req_ready, 0);
    @(posedge clk); @(negedge clk);
    // T2
    chk(phase == 3'd2, "R9 phase T2", phase, 2);
    if (wr) begin
      chk(ad_oe && den, "R3 write T2 drive", {ad_oe, den}, 2'b11);
      chk(ad_out == {4'h0, d}, "R3 write data on pins", ad_out, {4'h0, d});
    end else begin
      chk(!ad_oe && !den, "R3 read T2 float", {ad_oe, den}, 2'b00);
    end
    if (poke) begin
      chk(req_ready == 1'b0, "R10 not ready in T2", req_ready, 0);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h12345;
    end
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    // T3
    chk(phase == 3'd3, "R9 phase T3", phase, 3);
    chk(den && (ad_oe == wr), "R3 T3 enables", {den, ad_oe}, {1'b1, wr});
    bus_rdy = (waits == 0);
    @(posedge clk); @(negedge clk);
    for (int i = 0; i < waits; i++) begin
      chk(phase == 3'd4, "R4 wait state inserted", phase, 4);
      chk(den && (ad_oe == wr), "R3 wait enables", {den, ad_oe}, {1'b1, wr});
      bus_rdy = (i == waits - 1);
      @(posedge clk); @(negedge clk);
    end
    bus_rdy = 1'b1;
    // T4
    chk(phase == 3'd5, "R5 T4 after ready", phase, 5);
    chk(req_ready == 1'b1, "R7 ready in T4", req_ready, 1);
    if (!wr) ad_in = d;
    if (chain) begin
      req_valid = 1'b1; req_write = c_wr; req_addr = c_a; req_wdata = c_d;
    end
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    ad_in = 16'hDEAD;
    if (!wr) begin
      chk(rdata_valid == 1'b1, "R6 read valid pulse", rdata_valid, 1);
      chk(rdata == d, "R6 read data", rdata, d);
    end else begin
      chk(rdata_valid == 1'b0, "R6 no valid on write", rdata_valid, 0);
    end
    if (chain) begin
      chk(phase == 3'd1, "R7 back-to-back T1", phase, 1);
      chk(ad_out == c_a, "R7 chained address", ad_out, c_a);
    end else begin
      chk(phase == 3'd0, "R8 back to idle", phase, 0);
      chk(!ale && !ad_oe && !den && !dtr, "R8 idle quiet",
          {ale, ad_oe, den, dtr}, 0);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] prev;
    repeat (2) @(negedge clk);
    chk(phase == 3'd0 && !ale && !ad_oe && !den && !dtr, "R1 reset outputs",
        {phase, ale, ad_oe, den, dtr}, 0);
    chk(req_ready && !rdata_valid, "R1 reset ready", {req_ready, rdata_valid}, 2'b10);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(phase == 3'd0 && req_ready, "R1 idle after release", {phase, req_ready}, 1);

    for (int v = 0; v < NV; v++) begin
      run_txn(VEC[v][40], VEC[v][39:20], VEC[v][19:4], int'(VEC[v][3:0]),
              1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
      @(negedge clk);
    end

    // R8: no request keeps idle
    repeat (3) @(negedge clk);
    chk(phase == 3'd0 && !ad_oe, "R8 idle holds", {phase, ad_oe}, 0);

    // R7: read chained into write into read
    run_txn(1'b0, 20'h11111, 16'hC0DE, 1, 1'b0, 1'b0, 1'b1, 1'b1, 20'h22222, 16'h0F0F);
    run_txn(1'b1, 20'h22222, 16'h0F0F, 0, 1'b1, 1'b0, 1'b1, 1'b0, 20'h33333, 16'hA1B2);
    run_txn(1'b0, 20'h33333, 16'hA1B2, 2, 1'b1, 1'b0, 1'b0, 1'b0, '0, '0);

    // R10: request raised only in T2 is dropped
    run_txn(1'b1, 20'h44444, 16'h7777, 1, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0);
    @(negedge clk);
    chk(phase == 3'd0, "R10 stray request ignored", phase, 0);

    // R6: rdata holds across a write
    prev = rdata;
    run_txn(1'b1, 20'h55555, 16'h1111, 0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    chk(rdata == prev, "R6 rdata held over write", rdata, prev);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule